// File: doc/BRIEF.md
# Colour-Vector Fetch Address Arbiter

This block sits between the program counter and the instruction memory of an N-stage pipeline. It keeps a colour vector with one bit for each stage. Every fetch address it issues carries a copy of that vector, so the instruction fetched for the address can be marked with it. Sequential addresses arrive from the program counter. Any pipeline stage may also send a control-transfer target, such as a branch or exception address, together with the colour vector that stage holds. A stage that requests a transfer inverts its own bit in that vector.

Stages deeper in the pipeline outrank shallower ones. A transfer from stage k is refused when any vector bit above position k differs from the arbiter's stored copy. Such a difference means a deeper stage has already redirected the flow, so the request comes from a stream that is now dead. When the request is accepted, the target is issued, the stored vector takes the request's vector, and the program counter is told to reload from the target. Each request is answered with a one-cycle accept or reject pulse.

The fetch output is a registered valid/ready stream. While it holds a beat the memory has not taken, the program-counter input and all transfer inputs see ready low. No decision is made during that time.

Top module: `colour_arb_unit`

## Requirements
- R1: After reset the stored colour vector is all zeros and `fetch_valid` is low. The first address issued afterwards carries colour 0.
- R2: With no accepted transfer and a free output slot, `pc_ready` is high. A valid program-counter address is issued in the next cycle on `fetch_addr`, tagged with the stored vector on `fetch_colour`. Bit j of every colour vector belongs to stage j, and stage N-1 is the deepest.
- R3: When several stages request in the same cycle, only the deepest valid request (highest index) is arbitrated. Every other valid request gets a reject pulse in that cycle.
- R4: An arbitrated request from stage k is rejected exactly when its vector differs from the stored vector at some bit position j > k. Bits at positions k and below are not compared, so a request from stage N-1 is always accepted. A rejected request issues nothing and leaves the stored vector unchanged.
- R5: An accepted request issues its target address in the next cycle, tagged with the request's vector. The stored vector becomes that vector.
- R6: In a cycle with an accepted transfer, `pc_ready` is low, so the program-counter address is not taken.
- R7: In the cycle of an accept, `pc_load` pulses high and `pc_load_addr` carries the accepted target, so that sequential fetch continues from the target. Otherwise `pc_load` is low.
- R8: When `fetch_valid` is high and `fetch_ready` is low, the output beat is held stable. `pc_ready` and `xfer_ready` are low, and no accept or reject pulses occur.
- R9: Whenever `xfer_ready` is high, each valid request gets exactly one of `xfer_accept` or `xfer_reject` in that cycle. An invalid request gets neither, and at most one accept is given per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | Sequential address valid |
| pc_ready | output | 1 | Sequential address taken this cycle |
| pc_addr | input | ADDR_W | Sequential fetch address |
| pc_load | output | 1 | Program counter reload pulse |
| pc_load_addr | output | ADDR_W | Reload target |
| xfer_valid | input | N_STAGES | Per-stage transfer request, bit k from stage k |
| xfer_addr | input | N_STAGES*ADDR_W | Targets, stage k at bits [k*ADDR_W +: ADDR_W] |
| xfer_colour | input | N_STAGES*N_STAGES | Request vectors, stage k at bits [k*N_STAGES +: N_STAGES] |
| xfer_ready | output | 1 | Requests are decided this cycle |
| xfer_accept | output | N_STAGES | Per-stage accept pulse |
| xfer_reject | output | N_STAGES | Per-stage reject pulse |
| fetch_valid | output | 1 | Issued address valid |
| fetch_ready | input | 1 | Memory takes the issued address |
| fetch_addr | output | ADDR_W | Issued address |
| fetch_colour | output | N_STAGES | Colour vector tagged on the issued address |

## Verification
The bench targets cases where a shallower stage requests with a stale vector after a deeper stage has redirected. A design that compared the wrong bit range would let a dead-stream branch through, or would refuse a live one. It also drives simultaneous requests from several depths. A design with inverted priority would accept the shallow one and issue its target. Other cases are a request whose lower bits differ, which must still be accepted, and a transfer in the same cycle as a program-counter address, where a design without pre-emption would issue the wrong address or lose the reload pulse. Under back-pressure, a design that still arbitrated would update its vector, or drop a beat the memory had not taken.

// File: rtl/colour_arb_pkg.sv
package colour_arb_pkg;
  // outcome of arbitrating the winning transfer request in a cycle
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_TAKE = 2'd1,
    DEC_DROP = 2'd2
  } arb_dec_e;
endpackage

// File: rtl/cau_pick.sv
module cau_pick #(
  parameter int unsigned N_STAGES = 4
) (
  input  logic [N_STAGES-1:0] req,
  output logic [N_STAGES-1:0] win_oh,
  output logic                any
);
  // highest index wins: later iterations overwrite earlier ones
  always_comb begin
    win_oh = '0;
    for (int k = 0; k < N_STAGES; k++) begin
      if (req[k]) begin
        win_oh    = '0;
        win_oh[k] = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/cau_check.sv
module cau_check #(
  parameter int unsigned N_STAGES = 4
) (
  input  logic [N_STAGES-1:0]          win_oh,
  input  logic [N_STAGES*N_STAGES-1:0] req_colour,
  input  logic [N_STAGES-1:0]          held_colour,
  output logic                         pass
);
  logic [N_STAGES-1:0] stale;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    localparam logic [N_STAGES-1:0] HI_MASK = N_STAGES'({N_STAGES{1'b1}} << (k + 1));
    assign stale[k] = |((req_colour[k*N_STAGES +: N_STAGES] ^ held_colour) & HI_MASK);
  end

  assign pass = |(win_oh & ~stale);
endmodule

// File: rtl/cau_issue.sv
module cau_issue #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned N_STAGES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic [N_STAGES-1:0] load_colour,
  output logic                slot_free,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [N_STAGES-1:0] out_colour
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_colour <= '0;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) begin
        out_addr   <= load_addr;
        out_colour <= load_colour;
      end
    end
  end

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_colour)); // R8
endmodule

// File: rtl/colour_arb_unit.sv
module colour_arb_unit
  import colour_arb_pkg::*;
#(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned ADDR_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pc_valid,
  output logic                         pc_ready,
  input  logic [ADDR_W-1:0]            pc_addr,
  output logic                         pc_load,
  output logic [ADDR_W-1:0]            pc_load_addr,
  input  logic [N_STAGES-1:0]          xfer_valid,
  input  logic [N_STAGES*ADDR_W-1:0]   xfer_addr,
  input  logic [N_STAGES*N_STAGES-1:0] xfer_colour,
  output logic                         xfer_ready,
  output logic [N_STAGES-1:0]          xfer_accept,
  output logic [N_STAGES-1:0]          xfer_reject,
  output logic                         fetch_valid,
  input  logic                         fetch_ready,
  output logic [ADDR_W-1:0]            fetch_addr,
  output logic [N_STAGES-1:0]          fetch_colour
);
  logic [N_STAGES-1:0] held_colour;
  logic [N_STAGES-1:0] win_oh;
  logic                win_any;
  logic                win_pass;
  logic                slot_free;
  arb_dec_e            win_dec;
  logic                take;
  logic [ADDR_W-1:0]   sel_addr;
  logic [N_STAGES-1:0] sel_colour;
  logic                iss_load;
  logic [ADDR_W-1:0]   iss_addr;
  logic [N_STAGES-1:0] iss_colour;

  cau_pick #(.N_STAGES(N_STAGES)) i_pick (
    .req    (xfer_valid),
    .win_oh (win_oh),
    .any    (win_any)
  );

  cau_check #(.N_STAGES(N_STAGES)) i_check (
    .win_oh      (win_oh),
    .req_colour  (xfer_colour),
    .held_colour (held_colour),
    .pass        (win_pass)
  );

  // winning request's payload
  always_comb begin
    sel_addr   = '0;
    sel_colour = '0;
    for (int k = 0; k < N_STAGES; k++) begin
      if (win_oh[k]) begin
        sel_addr   = xfer_addr[k*ADDR_W +: ADDR_W];
        sel_colour = xfer_colour[k*N_STAGES +: N_STAGES];
      end
    end
  end

  always_comb begin
    if (!slot_free || !win_any) win_dec = DEC_IDLE;
    else if (win_pass)          win_dec = DEC_TAKE;
    else                        win_dec = DEC_DROP;
  end

  assign take         = (win_dec == DEC_TAKE);
  assign xfer_ready   = slot_free;
  assign xfer_accept  = take ? win_oh : '0;
  assign xfer_reject  = slot_free ? (xfer_valid & ~xfer_accept) : '0;
  assign pc_ready     = slot_free && !take;
  assign pc_load      = take;
  assign pc_load_addr = sel_addr;

  assign iss_load   = take || (pc_valid && pc_ready);
  assign iss_addr   = take ? sel_addr : pc_addr;
  assign iss_colour = take ? sel_colour : held_colour;

  always_ff @(posedge clk) begin
    if (!rst_n)    held_colour <= '0;
    else if (take) held_colour <= sel_colour;
  end

  cau_issue #(.ADDR_W(ADDR_W), .N_STAGES(N_STAGES)) i_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (iss_load),
    .load_addr   (iss_addr),
    .load_colour (iss_colour),
    .slot_free   (slot_free),
    .out_valid   (fetch_valid),
    .out_ready   (fetch_ready),
    .out_addr    (fetch_addr),
    .out_colour  (fetch_colour)
  );

  AST_ACK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_accept & xfer_reject) == '0); // R9
  AST_ACK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> ((xfer_accept | xfer_reject) == xfer_valid)); // R9
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_accept)); // R3
  AST_DEEPEST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid[N_STAGES-1] && xfer_ready |-> xfer_accept[N_STAGES-1]); // R4
  AST_TARGET_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_accept) |=> fetch_valid && fetch_addr == $past(pc_load_addr)); // R5
  AST_PC_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_accept) |-> !pc_ready && pc_load); // R6
  AST_QUIET_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |-> !xfer_ready && !pc_ready && xfer_accept == '0 && xfer_reject == '0); // R8
endmodule

// File: tb/test_colour_arb_unit.sv
module test_colour_arb_unit;
  localparam int N  = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pc_valid;
  logic          pc_ready;
  logic [AW-1:0] pc_addr;
  logic          pc_load;
  logic [AW-1:0] pc_load_addr;
  logic [N-1:0]  xfer_valid;
  logic [N*AW-1:0] xfer_addr;
  logic [N*N-1:0]  xfer_colour;
  logic          xfer_ready;
  logic [N-1:0]  xfer_accept, xfer_reject;
  logic          fetch_valid, fetch_ready;
  logic [AW-1:0] fetch_addr;
  logic [N-1:0]  fetch_colour;

  always #5 clk = ~clk;

  colour_arb_unit #(.N_STAGES(N), .ADDR_W(AW)) i_colour_arb_unit (
    .clk(clk), .rst_n(rst_n),
    .pc_valid(pc_valid), .pc_ready(pc_ready), .pc_addr(pc_addr),
    .pc_load(pc_load), .pc_load_addr(pc_load_addr),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_colour(xfer_colour),
    .xfer_ready(xfer_ready), .xfer_accept(xfer_accept), .xfer_reject(xfer_reject),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_colour(fetch_colour)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  logic [N-1:0]  m_col;
  logic          m_fv;
  logic [AW-1:0] m_fa;
  logic [N-1:0]  m_fc;

  logic [AW-1:0] ta [N];
  logic [N-1:0]  tc [N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare decisions, advance model, compare issued beat
  task automatic cyc(input logic [N-1:0] v, input bit pcv, input logic [AW-1:0] pca, input bit rdy);
    logic [N-1:0] e_acc, e_rej;
    int win;
    bit free;
    bit stale;
    logic [AW-1:0] e_la;
    xfer_valid  = v;
    pc_valid    = pcv;
    pc_addr     = pca;
    fetch_ready = rdy;
    for (int k = 0; k < N; k++) begin
      xfer_addr[k*AW +: AW] = ta[k];
      xfer_colour[k*N +: N] = tc[k];
    end
    #3;
    free  = !m_fv || rdy;
    win   = -1;
    for (int k = N - 1; k >= 0; k--) if (v[k] && win < 0) win = k;
    e_acc = '0;
    e_rej = '0;
    e_la  = '0;
    if (free) begin
      for (int k = 0; k < N; k++) begin
        if (v[k] && k != win) e_rej[k] = 1'b1;
      end
      if (win >= 0) begin
        stale = 0;
        for (int j = win + 1; j < N; j++) if (tc[win][j] != m_col[j]) stale = 1;
        if (stale) e_rej[win] = 1'b1;
        else e_acc[win] = 1'b1;
      end
    end
    chk(xfer_ready == free, "R8 xfer_ready", 64'(xfer_ready), 64'(free));
    chk(xfer_accept == e_acc, "R3/R4 xfer_accept", 64'(xfer_accept), 64'(e_acc));
    chk(xfer_reject == e_rej, "R3/R4/R9 xfer_reject", 64'(xfer_reject), 64'(e_rej));
    chk(pc_ready == (free && e_acc == '0), "R2/R6 pc_ready", 64'(pc_ready), 64'(free && e_acc == '0));
    chk(pc_load == (e_acc != '0), "R7 pc_load", 64'(pc_load), 64'(e_acc != '0));
    if (e_acc != '0) begin
      e_la = ta[win];
      chk(pc_load_addr == e_la, "R7 pc_load_addr", 64'(pc_load_addr), 64'(e_la));
    end
    @(posedge clk);
    #1;
    if (free) begin
      if (e_acc != '0) begin
        m_fv = 1; m_fa = ta[win]; m_fc = tc[win]; m_col = tc[win];
      end else if (pcv) begin
        m_fv = 1; m_fa = pca; m_fc = m_col;
      end else begin
        m_fv = 0;
      end
    end
    chk(fetch_valid == m_fv, "R2/R5 fetch_valid", 64'(fetch_valid), 64'(m_fv));
    if (m_fv) begin
      chk(fetch_addr == m_fa, "R2/R5 fetch_addr", 64'(fetch_addr), 64'(m_fa));
      chk(fetch_colour == m_fc, "R2/R5 fetch_colour", 64'(fetch_colour), 64'(m_fc));
    end
  endtask

  task automatic clr_req();
    for (int k = 0; k < N; k++) begin
      ta[k] = '0;
      tc[k] = '0;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lf;
    logic [N-1:0] rv;
    rst_n = 1'b0;
    pc_valid = 0; pc_addr = '0; fetch_ready = 1;
    xfer_valid = '0; xfer_addr = '0; xfer_colour = '0;
    clr_req();
    m_col = '0; m_fv = 0; m_fa = '0; m_fc = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset state
    chk(fetch_valid == 1'b0, "R1 fetch_valid after reset", 64'(fetch_valid), 64'd0);
    cyc('0, 1, 16'h0100, 1);
    chk(fetch_colour == '0, "R1 first colour", 64'(fetch_colour), 64'd0);

    // R2: sequential stream
    cyc('0, 1, 16'h0101, 1);
    cyc('0, 1, 16'h0102, 1);

    // R5/R6/R7: stage 1 redirects, own bit flipped, PC competing
    ta[1] = 16'h2000; tc[1] = 4'b0010;
    cyc(4'b0010, 1, 16'h0103, 1);
    cyc('0, 1, 16'h2001, 1);

    // R4: stage 0 with stale bit 1 is rejected, vector unchanged
    ta[0] = 16'h3000; tc[0] = 4'b0001;
    cyc(4'b0001, 1, 16'h2002, 1);
    cyc('0, 1, 16'h2003, 1);

    // R3: stage 0 and stage 2 together, deeper wins
    ta[0] = 16'h3100; tc[0] = 4'b0011;
    ta[2] = 16'h4000; tc[2] = 4'b0110;
    cyc(4'b0101, 1, 16'h2004, 1);

    // R4: deepest stage accepted with any lower bits
    ta[3] = 16'h5000; tc[3] = 4'b1001;
    cyc(4'b1000, 0, 16'h0, 1);

    // R4: lower bits differ but upper bits agree -> accepted
    ta[2] = 16'h6000; tc[2] = 4'b1110;
    cyc(4'b0100, 1, 16'h5001, 1);

    // R8: back-pressure with requests and PC pending
    ta[3] = 16'h7000; tc[3] = 4'b0110;
    cyc(4'b1000, 1, 16'h6001, 0);
    cyc(4'b1001, 1, 16'h6001, 0);
    cyc('0, 1, 16'h6001, 1);

    // mixed traffic against the model
    lf = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < N; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        ta[k] = lf[15:0];
        if (lf[20]) tc[k] = m_col ^ N'(1 << k);
        else        tc[k] = lf[27:24];
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rv = (lf[3:0] & lf[7:4]);
      cyc(rv, lf[9], lf[31:16], lf[10] | lf[11]);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule